// File: doc/BRIEF.md
# Configuration Image Loader with Resident-Signature Register

This block copies a stored configuration image from memory into a 32-bit configuration write port, without processor help. Software fills a small slot table through an APB slave. Each slot gives a word-aligned start address, a length in 32-bit words and a 16-bit signature for one loadable module. A one-cycle `load_req` with a slot index starts the copy. The engine then reads memory in sequential bursts over a simple request/response interface. It parks each word in a FIFO and streams it to the configuration sink.

Memory read requests are reserved against FIFO space. A burst is requested only when every word of it is sure to find a free FIFO slot. For this reason the response channel has no ready signal. The configuration sink can take one word per clock whenever the FIFO holds data. The sink port is valid/ready: `cfg_valid` and `cfg_data` stay unchanged while `cfg_ready` is low, and a word moves only on a cycle where both are high. The memory request port follows the same rule: `mrd_valid`, `mrd_addr` and `mrd_len` stay unchanged until `mrd_ready` is sampled high.

A status register holds the signature of the module now resident. Software reads it to learn which core is present. While a copy is in progress it reads a reserved "loading" value. APB transfers complete without wait states.

Top module: `cfg_loader`

## Requirements
- R1: Slot i (0..3) sits at APB offset 16*i. Offset +0 is the start byte address, with bits 1:0 always read as zero. Offset +4 is the length in words (bits 15:0). Offset +8 is the signature (bits 15:0). The status register sits at offset 0x40 and returns the resident signature in bits 15:0. All fields read back what was last written.
- R2: A `load_req` sampled while idle, for a slot of nonzero length, copies that slot's image. Memory words at start, start+4, start+8, and so on appear on `cfg_data` in that order, each exactly once, for exactly the slot's length.
- R3: Memory requests are contiguous and start at the slot's start address. Each requests min(8, words not yet requested) words. `mrd_valid`, `mrd_addr` and `mrd_len` hold steady until accepted.
- R4: A burst is issued only if the words requested but not yet delivered, together with this burst, number no more than the FIFO depth (16).
- R5: While `cfg_valid` is high and `cfg_ready` is low, `cfg_valid` stays high and `cfg_data` stays unchanged on the next cycle.
- R6: From the cycle after a nonzero-length request is accepted until the final word is delivered, the status register reads 0xFFFF and `busy` is high.
- R7: In the cycle after the final word is accepted, `done` is high for exactly one cycle. At the same time `busy` falls and the status register takes the slot's signature.
- R8: A `load_req` that arrives while `busy` is high is ignored. The running copy's word count and final signature do not change.
- R9: A request for a slot of zero length issues no memory request. It raises `done` in the next cycle and stores that slot's signature.
- R10: After reset the block is idle: `busy`, `done`, `mrd_valid` and `cfg_valid` are low, and the status register reads 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when high |
| paddr | input | 8 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| load_req | input | 1 | One-cycle request to load a slot |
| load_idx | input | 2 | Slot index for the request |
| busy | output | 1 | A copy is in progress |
| done | output | 1 | One-cycle completion pulse |
| mrd_valid | output | 1 | Memory burst request valid |
| mrd_ready | input | 1 | Memory accepts the request |
| mrd_addr | output | 32 | Burst start byte address |
| mrd_len | output | 4 | Burst length in words (1..8) |
| mrsp_valid | input | 1 | Memory response word valid |
| mrsp_data | input | 32 | Memory response word |
| cfg_valid | output | 1 | Configuration word valid |
| cfg_ready | input | 1 | Configuration sink accepts the word |
| cfg_data | output | 32 | Configuration word |

## Verification
The assertions assume the memory returns exactly the words it was asked for, in request order, and never more than are outstanding. That assumption is what makes the no-overflow property meaningful. They also assume no slot is given the signature 0xFFFF. The bench memory model queues the addresses of each accepted burst and replays them one by one, sometimes with gaps, so it never volunteers a word. All slot signatures it programs differ from the loading value.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
  localparam logic [15:0] SIG_LOADING = 16'hFFFF;
  localparam logic [15:0] SIG_EMPTY   = 16'h0000;

  typedef enum logic {LD_IDLE, LD_RUN} ld_state_t;

  typedef struct packed {
    logic [29:0] word_addr;
    logic [15:0] words;
    logic [15:0] sig;
  } slot_t;
endpackage

// File: rtl/loader_table.sv
module loader_table
  import cfg_loader_pkg::*;
#(
  parameter int SLOTS = 4,
  parameter int AW    = 8,
  localparam int IW   = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [AW-1:0] paddr,
  input  logic [31:0]   pwdata,
  output logic [31:0]   prdata,
  input  logic [IW-1:0] slot_idx,
  output slot_t         slot_q,
  input  logic          st_start,
  input  logic          st_commit,
  input  logic [15:0]   commit_sig,
  output logic [15:0]   status_sig
);
  slot_t tbl [SLOTS];
  logic  wr_en;
  logic  unused_bits;

  assign wr_en       = psel && penable && pwrite;
  assign unused_bits = ^{pwdata[31:16], paddr[1:0]};

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        tbl[g] <= '0;
      end else if (wr_en && paddr[AW-1:4] == (AW-4)'(g)) begin
        case (paddr[3:2])
          2'd0:    tbl[g].word_addr <= pwdata[31:2];
          2'd1:    tbl[g].words     <= pwdata[15:0];
          2'd2:    tbl[g].sig       <= pwdata[15:0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         status_sig <= SIG_EMPTY;
    else if (st_commit) status_sig <= commit_sig;
    else if (st_start)  status_sig <= SIG_LOADING;
  end

  always_comb begin
    prdata = '0;
    if (paddr == AW'(SLOTS * 16)) begin
      prdata = {16'h0000, status_sig};
    end else if (paddr[AW-1:4] < (AW-4)'(SLOTS)) begin
      case (paddr[3:2])
        2'd0:    prdata = {tbl[paddr[IW+3:4]].word_addr, 2'b00};
        2'd1:    prdata = {16'h0000, tbl[paddr[IW+3:4]].words};
        2'd2:    prdata = {16'h0000, tbl[paddr[IW+3:4]].sig};
        default: prdata = '0;
      endcase
    end
  end

  assign slot_q = tbl[slot_idx];
endmodule

// File: rtl/loader_fifo.sv
module loader_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] dout,
  output logic         full
);
  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          pop, wr;

  assign out_valid = (cnt != '0);
  assign full      = (cnt == (AW+1)'(DEPTH));
  assign pop       = out_valid && out_ready;
  assign wr        = push && !full;
  assign dout      = mem[rp];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (wr)  wp <= wp + 1'b1;
      if (pop) rp <= rp + 1'b1;
      cnt <= cnt + (wr ? (AW+1)'(1) : '0) - (pop ? (AW+1)'(1) : '0);
    end
  end

  always_ff @(posedge clk) begin
    if (wr) mem[wp] <= din;
  end

  // R4: space reservation means a response never meets a full buffer
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

  // R5: a stalled word stays presented and unchanged
  p_cfg_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(dout));
endmodule

// File: rtl/loader_fetch.sv
module loader_fetch
  import cfg_loader_pkg::*;
#(
  parameter int BURST = 8,
  parameter int DEPTH = 16,
  localparam int BLW  = $clog2(BURST + 1),
  localparam int PW   = $clog2(DEPTH + BURST + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load_req,
  input  slot_t          slot,
  input  logic           out_fire,
  output logic           mrd_valid,
  input  logic           mrd_ready,
  output logic [31:0]    mrd_addr,
  output logic [BLW-1:0] mrd_len,
  output logic           busy,
  output logic           done,
  output logic           st_start,
  output logic           st_commit,
  output logic [15:0]    commit_sig
);
  ld_state_t      state;
  logic [29:0]    cur_addr, req_a;
  logic [15:0]    req_left, out_left, burst_now, held_sig;
  logic [PW-1:0]  pend;
  logic [BLW-1:0] req_n;
  logic           req_v, done_q, can_issue, last_out, zero_go;

  assign burst_now = (req_left >= 16'(BURST)) ? 16'(BURST) : req_left;
  assign can_issue = (state == LD_RUN) && !req_v && (req_left != '0) &&
                     (pend + PW'(burst_now) <= PW'(DEPTH));
  assign last_out  = (state == LD_RUN) && out_fire && (out_left == 16'd1);
  assign st_start  = (state == LD_IDLE) && load_req && (slot.words != '0);
  assign zero_go   = (state == LD_IDLE) && load_req && (slot.words == '0);
  assign st_commit = last_out || zero_go;
  assign commit_sig = zero_go ? slot.sig : held_sig;

  assign mrd_valid = req_v;
  assign mrd_addr  = {req_a, 2'b00};
  assign mrd_len   = req_n;
  assign busy      = (state == LD_RUN);
  assign done      = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= LD_IDLE;
      cur_addr <= '0;
      req_left <= '0;
      out_left <= '0;
      held_sig <= '0;
      pend     <= '0;
      req_v    <= 1'b0;
      req_a    <= '0;
      req_n    <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= st_commit;
      if (req_v && mrd_ready) req_v <= 1'b0;
      pend <= pend + (can_issue ? PW'(burst_now) : '0) - (out_fire ? PW'(1) : '0);
      case (state)
        LD_IDLE: begin
          if (st_start) begin
            state    <= LD_RUN;
            cur_addr <= slot.word_addr;
            req_left <= slot.words;
            out_left <= slot.words;
            held_sig <= slot.sig;
          end
        end
        default: begin
          if (can_issue) begin
            req_v    <= 1'b1;
            req_a    <= cur_addr;
            req_n    <= BLW'(burst_now);
            cur_addr <= cur_addr + 30'(burst_now);
            req_left <= req_left - burst_now;
          end
          if (out_fire) out_left <= out_left - 16'd1;
          if (last_out) state <= LD_IDLE;
        end
      endcase
    end
  end

  // R3: an offered burst request is held until accepted
  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mrd_valid && !mrd_ready |=> mrd_valid && $stable(mrd_addr) && $stable(mrd_len));

  // R7: completion is a single-cycle pulse
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7: completion coincides with the engine being idle
  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
  import cfg_loader_pkg::*;
#(
  parameter int SLOTS      = 4,
  parameter int BURST      = 8,
  parameter int FIFO_DEPTH = 16,
  parameter int APB_AW     = 8,
  localparam int IW        = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int BLW       = $clog2(BURST + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [APB_AW-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  input  logic              load_req,
  input  logic [IW-1:0]     load_idx,
  output logic              busy,
  output logic              done,
  output logic              mrd_valid,
  input  logic              mrd_ready,
  output logic [31:0]       mrd_addr,
  output logic [BLW-1:0]    mrd_len,
  input  logic              mrsp_valid,
  input  logic [31:0]       mrsp_data,
  output logic              cfg_valid,
  input  logic              cfg_ready,
  output logic [31:0]       cfg_data
);
  slot_t       slot_q;
  logic        st_start, st_commit, fifo_full, out_fire;
  logic [15:0] commit_sig, status_sig;

  assign out_fire = cfg_valid && cfg_ready;

  loader_table #(.SLOTS(SLOTS), .AW(APB_AW)) u_table (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .slot_idx(load_idx),
    .slot_q(slot_q), .st_start(st_start), .st_commit(st_commit),
    .commit_sig(commit_sig), .status_sig(status_sig)
  );

  loader_fetch #(.BURST(BURST), .DEPTH(FIFO_DEPTH)) u_fetch (
    .clk(clk), .rst_n(rst_n), .load_req(load_req), .slot(slot_q),
    .out_fire(out_fire), .mrd_valid(mrd_valid), .mrd_ready(mrd_ready),
    .mrd_addr(mrd_addr), .mrd_len(mrd_len), .busy(busy), .done(done),
    .st_start(st_start), .st_commit(st_commit), .commit_sig(commit_sig)
  );

  loader_fifo #(.W(32), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(mrsp_valid), .din(mrsp_data),
    .out_valid(cfg_valid), .out_ready(cfg_ready), .dout(cfg_data), .full(fifo_full)
  );

  // R6: while a copy runs, software sees the loading marker
  p_loading_sig_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> status_sig == SIG_LOADING);
endmodule

// File: tb/cfg_loader_test.sv
module cfg_loader_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        load_req = 1'b0;
  logic [1:0]  load_idx = '0;
  logic        busy, done, mrd_valid, cfg_valid;
  logic        mrd_ready = 1'b0, mrsp_valid = 1'b0, cfg_ready = 1'b0;
  logic [31:0] mrd_addr, cfg_data;
  logic [31:0] mrsp_data = '0;
  logic [3:0]  mrd_len;

  int checks = 0, errors = 0, cyc = 0;
  int exp_len = -1, acc = 0, rem = 0, issued = 0, bursts = 0, done_cnt = 0;
  int cfg_mode = 0, mem_mode = 0, qh = 0, qt = 0;
  logic [31:0] exp_base = '0, exp_next = '0;
  logic [31:0] mq [0:127];
  bit prev_final = 1'b0;

  always #10 clk = ~clk;

  cfg_loader uut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .load_req(load_req),
    .load_idx(load_idx), .busy(busy), .done(done), .mrd_valid(mrd_valid),
    .mrd_ready(mrd_ready), .mrd_addr(mrd_addr), .mrd_len(mrd_len),
    .mrsp_valid(mrsp_valid), .mrsp_data(mrsp_data), .cfg_valid(cfg_valid),
    .cfg_ready(cfg_ready), .cfg_data(cfg_data)
  );

  function automatic logic [31:0] mw(input logic [31:0] a);
    return {a[15:0] ^ 16'h3C5A, a[31:16] ^ ~a[15:0]};
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // memory model, sink model and cycle monitor
  always @(negedge clk) begin
    bit nf;
    if (rst_n) begin
      cyc++;
      if (done || prev_final) chk(done == prev_final, "R7/R9 done timing", done, prev_final);
      if (done) done_cnt++;
      nf = 1'b0;
      if (load_req && !busy && exp_len == 0) nf = 1'b1;
      cfg_ready = (cfg_mode == 0) ? 1'b1 : (cyc % 3 == 0);
      if (cfg_valid && cfg_ready) begin
        chk(cfg_data == mw(exp_base + 32'(4 * acc)), "R2 word data/order",
            cfg_data, mw(exp_base + 32'(4 * acc)));
        acc++;
        if (acc == exp_len) nf = 1'b1;
      end
      prev_final = nf;
      if (qh != qt && (mem_mode == 0 || cyc % 2 == 0)) begin
        mrsp_valid = 1'b1;
        mrsp_data  = mw(mq[qh % 128]);
        qh++;
      end else begin
        mrsp_valid = 1'b0;
      end
      mrd_ready = (mem_mode == 0) ? 1'b1 : (cyc % 4 != 1);
      if (mrd_valid && mrd_ready) begin
        int en;
        en = (rem > 8) ? 8 : rem;
        chk(mrd_addr == exp_next, "R3 burst address", mrd_addr, exp_next);
        chk(int'(mrd_len) == en, "R3 burst length", mrd_len, en);
        chk(issued + int'(mrd_len) - acc <= 16, "R4 reserved space",
            issued + int'(mrd_len) - acc, 16);
        for (int k = 0; k < int'(mrd_len); k++) begin
          mq[qt % 128] = mrd_addr + 32'(4 * k);
          qt++;
        end
        exp_next = exp_next + 32'(4 * int'(mrd_len));
        rem    -= int'(mrd_len);
        issued += int'(mrd_len);
        bursts++;
      end
    end
  end

  task automatic apb_wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #5;
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
    @(posedge clk); #5;
    penable = 1'b1;
    @(posedge clk); #5;
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apb_rd(input logic [7:0] a, output logic [31:0] d);
    @(posedge clk); #5;
    psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
    @(posedge clk); #5;
    penable = 1'b1;
    d = prdata;
    @(posedge clk); #5;
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #5 rst_n = 1'b1;
    @(posedge clk); #5;
    chk(!busy, "R10 busy after reset", busy, 0);
    chk(!done, "R10 done after reset", done, 0);
    chk(!mrd_valid, "R10 mrd_valid after reset", mrd_valid, 0);
    chk(!cfg_valid, "R10 cfg_valid after reset", cfg_valid, 0);
    apb_rd(8'h40, d);
    chk(d == 32'h0, "R10 status after reset", d, 0);
  endtask

  task automatic t_program();
    logic [31:0] d;
    apb_wr(8'h00, 32'h0000_1003); apb_wr(8'h04, 32'd20); apb_wr(8'h08, 32'h0A11);
    apb_wr(8'h10, 32'h0000_2004); apb_wr(8'h14, 32'd1);  apb_wr(8'h18, 32'h0B22);
    apb_wr(8'h20, 32'h0000_3000); apb_wr(8'h24, 32'd37); apb_wr(8'h28, 32'h0C33);
    apb_wr(8'h30, 32'h0000_4000); apb_wr(8'h34, 32'd0);  apb_wr(8'h38, 32'h0D44);
    apb_rd(8'h00, d); chk(d == 32'h1000, "R1 slot0 address low bits cleared", d, 32'h1000);
    apb_rd(8'h24, d); chk(d == 32'd37, "R1 slot2 length", d, 37);
    apb_rd(8'h38, d); chk(d == 32'h0D44, "R1 slot3 signature", d, 32'h0D44);
    apb_rd(8'h40, d); chk(d == 32'h0, "R1 status unchanged by table writes", d, 0);
  endtask

  task automatic t_load(input int idx, input logic [31:0] base, input int len,
                        input logic [15:0] sig, input int cm, input int mm, input bit poke);
    logic [31:0] d;
    int start, waited;
    cfg_mode = cm; mem_mode = mm;
    exp_base = base; exp_next = base; exp_len = len; rem = len;
    acc = 0; issued = 0; bursts = 0; qh = 0; qt = 0;
    start = done_cnt;
    @(posedge clk); #5;
    load_req = 1'b1; load_idx = 2'(idx);
    @(posedge clk); #5;
    load_req = 1'b0;
    if (len > 0) begin
      chk(busy, "R6 busy after request", busy, 1);
      apb_rd(8'h40, d);
      chk(d == 32'hFFFF, "R6 loading marker", d, 32'hFFFF);
      if (poke) begin
        @(posedge clk); #5;
        load_req = 1'b1; load_idx = 2'd1;
        @(posedge clk); #5;
        load_req = 1'b0;
        chk(busy, "R8 still busy after ignored request", busy, 1);
      end
    end
    waited = 0;
    while (done_cnt == start && waited < 3000) begin
      @(posedge clk); waited++;
    end
    #5;
    chk(done_cnt == start + 1, "R7 done pulse seen", done_cnt - start, 1);
    repeat (4) @(posedge clk);
    #5;
    chk(acc == len, poke ? "R8 word count unchanged" : "R2 word count", acc, len);
    chk(bursts == (len + 7) / 8, len == 0 ? "R9 no memory request" : "R3 burst count",
        bursts, (len + 7) / 8);
    chk(!busy, "R7 idle after completion", busy, 0);
    chk(done_cnt == start + 1, "R7 single done pulse", done_cnt - start, 1);
    apb_rd(8'h40, d);
    chk(d == {16'h0, sig}, len == 0 ? "R9 zero-length signature" :
        (poke ? "R8 signature of running copy" : "R7 resident signature"), d, sig);
  endtask

  initial begin
    t_reset();
    t_program();
    t_load(0, 32'h1000, 20, 16'h0A11, 0, 0, 1'b0);
    t_load(2, 32'h3000, 37, 16'h0C33, 1, 1, 1'b1);
    t_load(1, 32'h2004, 1,  16'h0B22, 0, 1, 1'b0);
    t_load(3, 32'h4000, 0,  16'h0D44, 0, 0, 1'b0);
    t_load(0, 32'h1000, 20, 16'h0A11, 1, 0, 1'b0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule